// File: doc/BRIEF.md
# Sensor Output Register Lock

This block holds the six measurement bytes of a tri-axis sensor and makes sure that a host reading them over a byte-wide bus always sees one coherent sample. A measurement engine delivers each new sample as a six-byte bundle with a one-cycle write strobe. The bus interface reads the bytes one at a time by index. As soon as the host has read any byte of a set, the whole set is frozen until every byte has been read, or until a reset, a mode change or a measurement-setting change releases it.

Samples that arrive while the set is frozen are parked in a holding buffer. Only the newest one is kept, and it is moved into the output bytes as soon as the freeze ends. The block also builds a status byte that carries a ready flag, a lock flag and a regulator-enabled flag, and drives a data-ready pin that mirrors the ready flag. The ready flag drops whenever the output bytes are rewritten or the device is in its off mode. Once it has dropped, it stays low for a programmable minimum number of clock cycles, which gives 5 µs at the default setting and a 50 MHz clock.

Top module: `magLockTop`

## Requirements
- R1: `sampleData[47:40]` is byte index 0 (X high), then in turn X low, Z high, Z low and Y high, down to `sampleData[7:0]`, which is index 5 (Y low). `rdData` shows the byte selected by `rdIndex` in the same cycle. An index of 6 or 7 reads 0 and a read strobe on it has no effect on the lock.
- R2: After reset, `statusByte` is 0, `drdy` is 0 and all six output bytes read 0.
- R3: A read strobe on a valid index while unlocked sets the lock flag (`statusByte[1]`) from the next cycle on.
- R4: The lock flag clears in the cycle after the last of the six distinct indexes has been read. Reading the same index again does not count toward the six.
- R5: A `modeChange` or `configChange` pulse clears the lock flag in the next cycle.
- R6: A sample that arrives while the lock is set, or in the same cycle as a valid read strobe, does not change the output bytes.
- R7: A held sample is copied into the output bytes one cycle after the lock has cleared. A second arrival replaces the first one held.
- R8: Loading a sample clears the ready flag in the next cycle. With no other event, the flag rises again exactly `LOW_CYC`+1 cycles after the load edge, so it is never low for fewer than `LOW_CYC` cycles.
- R9: While `offMode` is high the ready flag is 0. A set that is still pending completes `LOW_CYC`+1 cycles after the last cycle with `offMode` high. If nothing is pending, the flag stays 0.
- R10: `statusByte` has bits 7 to 3 at 0, bit 2 equal to `regOn` registered one cycle, bit 1 as the lock flag and bit 0 as the ready flag. `drdy` always equals bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| sampleValid | input | 1 | One-cycle strobe: new sample on `sampleData` |
| sampleData | input | 48 | Six-byte sample, index 0 in the top byte |
| rdStrobe | input | 1 | One byte is being read this cycle |
| rdIndex | input | 3 | Byte index for reading (0 to 5) |
| rdData | output | 8 | Selected output byte (combinational) |
| modeChange | input | 1 | Operating mode changed; releases the lock |
| configChange | input | 1 | Measurement setting changed; releases the lock |
| offMode | input | 1 | Device is in its off mode |
| regOn | input | 1 | Internal regulator is enabled |
| statusByte | output | 8 | Status: regulator, lock and ready flags |
| drdy | output | 1 | Data-ready pin |

## Verification
`rdData` is combinational, so the bench checks it in the same cycle as it sets `rdIndex`, before the next edge. The lock flag, the regulator bit and the clearing of ready all change at the first edge after their stimulus, and the bench samples them one time unit after that edge. A held sample needs two edges after the release pulse (one to clear the lock, one to copy the sample), and the bench checks the old byte after the first edge and the new byte after the second. The rise of ready comes `LOW_CYC`+1 edges after the load or after the last cycle with `offMode` high. The bench checks that ready is still 0 after `LOW_CYC` edges and that it has risen after one more edge.

// File: rtl/magLockPkg.sv
package magLockPkg;
  parameter int unsigned NUM_BYTES = 6;
  parameter int unsigned BYTE_W    = 8;

  // strobes sent from the control to the datapath
  typedef struct packed {
    logic loadNew;     // copy incoming sample into output bytes
    logic loadHeld;    // copy held sample into output bytes
    logic captureHeld; // park incoming sample in holding buffer
  } dpStrobe_t;
endpackage

// File: rtl/magLockData.sv
module magLockData
  import magLockPkg::*;
#(
  parameter int unsigned NB = NUM_BYTES,
  parameter int unsigned BW = BYTE_W,
  localparam int unsigned IW = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       strobe,
  input  logic [NB*BW-1:0] sampleData,
  input  logic [IW-1:0]   rdIndex,
  output logic [BW-1:0]   rdData,
  output logic [NB*BW-1:0] outFlat
);
  logic [BW-1:0] outReg  [NB];
  logic [BW-1:0] heldReg [NB];

  for (genvar g = 0; g < NB; g++) begin : gLane
    localparam int unsigned LO = (NB - 1 - g) * BW;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outReg[g]  <= '0;
        heldReg[g] <= '0;
      end else begin
        if (strobe.loadNew)       outReg[g] <= sampleData[LO +: BW];
        else if (strobe.loadHeld) outReg[g] <= heldReg[g];
        if (strobe.captureHeld)   heldReg[g] <= sampleData[LO +: BW];
      end
    end
    assign outFlat[LO +: BW] = outReg[g];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NB; i++) begin
      if ({1'b0, rdIndex} == (IW+1)'(i)) rdData = outReg[i];
    end
  end
endmodule

// File: rtl/magLockCtrl.sv
module magLockCtrl
  import magLockPkg::*;
#(
  parameter int unsigned NB      = NUM_BYTES,
  parameter int unsigned LOW_CYC = 250,
  localparam int unsigned IW = $clog2(NB),
  localparam int unsigned CW = $clog2(LOW_CYC + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic          rdStrobe,
  input  logic [IW-1:0] rdIndex,
  input  logic          modeChange,
  input  logic          configChange,
  input  logic          offMode,
  input  logic          regOn,
  output dpStrobe_t     strobe,
  output logic          lockFlag,
  output logic          readyFlag,
  output logic          regFlag
);
  logic [NB-1:0] readMask, readOh, merged;
  logic          rdHit, release_, blocked, heldValid, pendSet, anyLoad;
  logic [CW-1:0] lowCnt;

  assign rdHit    = rdStrobe && ({1'b0, rdIndex} < (IW+1)'(NB));
  assign readOh   = rdHit ? (NB'(1) << rdIndex) : '0;
  assign merged   = readMask | readOh;
  assign release_ = modeChange | configChange;
  assign lockFlag = |readMask;
  // a read in flight also blocks, so that the byte just read stays in its set
  assign blocked  = lockFlag | rdHit;

  always_comb begin
    strobe.loadNew     = sampleValid && !blocked;
    strobe.loadHeld    = heldValid && !sampleValid && !blocked;
    strobe.captureHeld = sampleValid && blocked;
  end
  assign anyLoad = strobe.loadNew | strobe.loadHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readMask  <= '0;
      heldValid <= 1'b0;
      regFlag   <= 1'b0;
    end else begin
      regFlag <= regOn;
      if (release_ || (&merged)) readMask <= '0;
      else                       readMask <= merged;
      if (strobe.captureHeld) heldValid <= 1'b1;
      else if (anyLoad)       heldValid <= 1'b0;
    end
  end

  // ready flag with minimum low time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyFlag <= 1'b0;
      pendSet   <= 1'b0;
      lowCnt    <= '0;
    end else if (anyLoad || offMode) begin
      readyFlag <= 1'b0;
      lowCnt    <= CW'(LOW_CYC);
      if (anyLoad) pendSet <= 1'b1;
    end else if (lowCnt != '0) begin
      lowCnt <= lowCnt - 1'b1;
    end else if (pendSet) begin
      readyFlag <= 1'b1;
      pendSet   <= 1'b0;
    end
  end
endmodule

// File: rtl/magLockTop.sv
module magLockTop
  import magLockPkg::*;
#(
  parameter int unsigned NB      = NUM_BYTES,
  parameter int unsigned BW      = BYTE_W,
  parameter int unsigned LOW_CYC = 250,
  localparam int unsigned IW = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [NB*BW-1:0] sampleData,
  input  logic             rdStrobe,
  input  logic [IW-1:0]    rdIndex,
  output logic [BW-1:0]    rdData,
  input  logic             modeChange,
  input  logic             configChange,
  input  logic             offMode,
  input  logic             regOn,
  output logic [BW-1:0]    statusByte,
  output logic             drdy
);
  dpStrobe_t        strobe;
  logic             lockFlag, readyFlag, regFlag;
  logic [NB*BW-1:0] outFlat;

  magLockCtrl #(.NB(NB), .LOW_CYC(LOW_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .rdStrobe(rdStrobe),
    .rdIndex(rdIndex), .modeChange(modeChange), .configChange(configChange),
    .offMode(offMode), .regOn(regOn), .strobe(strobe), .lockFlag(lockFlag),
    .readyFlag(readyFlag), .regFlag(regFlag)
  );

  magLockData #(.NB(NB), .BW(BW)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleData(sampleData),
    .rdIndex(rdIndex), .rdData(rdData), .outFlat(outFlat)
  );

  assign statusByte = {(BW-3)'(0), regFlag, lockFlag, readyFlag};
  assign drdy       = readyFlag;
endmodule

// File: rtl/magLockChecker.sv
module magLockChecker #(
  parameter int unsigned NB      = 6,
  parameter int unsigned BW      = 8,
  parameter int unsigned LOW_CYC = 250,
  localparam int unsigned IW = $clog2(NB),
  localparam int unsigned CW = $clog2(LOW_CYC + 2) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdStrobe,
  input logic [IW-1:0]    rdIndex,
  input logic             modeChange,
  input logic             configChange,
  input logic             offMode,
  input logic [BW-1:0]    statusByte,
  input logic [NB*BW-1:0] outFlat
);
  logic          lock, ready;
  logic [CW-1:0] lowSeen;
  assign lock  = statusByte[1];
  assign ready = statusByte[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lowSeen <= '0;
    else if (ready)            lowSeen <= '0;
    else if (lowSeen != '1)    lowSeen <= lowSeen + 1'b1;
  end

  // R8: ready only rises after at least LOW_CYC low cycles
  a_r8_min_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (lowSeen >= CW'(LOW_CYC)));

  // R6: output bytes frozen while locked
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rstN)
    lock |=> $stable(outFlat));

  // R9: off mode forces ready low
  a_r9_off_clears: assert property (@(posedge clk) disable iff (!rstN)
    offMode |=> !ready);

  // R5: mode or setting change releases the lock
  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    (modeChange || configChange) |=> !lock);

  // R3: first valid read while unlocked sets the lock
  a_r3_lock_set: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && ({1'b0, rdIndex} < (IW+1)'(NB)) && !modeChange && !configChange && !lock)
      |=> lock);
endmodule

bind magLockTop magLockChecker #(.NB(NB), .BW(BW), .LOW_CYC(LOW_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .rdIndex(rdIndex),
  .modeChange(modeChange), .configChange(configChange), .offMode(offMode),
  .statusByte(statusByte), .outFlat(outFlat)
);

// File: tb/sim_magLockTop.sv
module sim_magLockTop;
  localparam int unsigned LOWC = 250;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [47:0] sampleData = '0;
  logic        rdStrobe = 1'b0;
  logic [2:0]  rdIndex = '0;
  logic [7:0]  rdData;
  logic        modeChange = 1'b0;
  logic        configChange = 1'b0;
  logic        offMode = 1'b0;
  logic        regOn = 1'b0;
  logic [7:0]  statusByte;
  logic        drdy;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  magLockTop #(.LOW_CYC(LOWC)) u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .rdStrobe(rdStrobe), .rdIndex(rdIndex), .rdData(rdData),
    .modeChange(modeChange), .configChange(configChange), .offMode(offMode),
    .regOn(regOn), .statusByte(statusByte), .drdy(drdy)
  );

  localparam logic [47:0] SA = 48'hA1A2A3A4A5A6;
  localparam logic [47:0] SB = 48'hB1B2B3B4B5B6;
  localparam logic [47:0] SC = 48'hC1C2C3C4C5C6;
  localparam logic [47:0] SD = 48'hD1D2D3D4D5D6;
  localparam logic [47:0] SE = 48'hE1E2E3E4E5E6;

  // read table: [11:9] index, [8:1] expected byte, [0] lock after the read
  localparam logic [11:0] RD_TAB [8] = '{
    {3'd0, 8'hA1, 1'b1}, {3'd0, 8'hA1, 1'b1}, {3'd3, 8'hA4, 1'b1},
    {3'd5, 8'hA6, 1'b1}, {3'd1, 8'hA2, 1'b1}, {3'd2, 8'hA3, 1'b1},
    {3'd4, 8'hA5, 1'b0}, {3'd6, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic readByte(input logic [2:0] idx);
    rdStrobe = 1'b1; rdIndex = idx;
    tick();
    rdStrobe = 1'b0;
  endtask

  task automatic sendSample(input logic [47:0] d);
    sampleValid = 1'b1; sampleData = d;
    tick();
    sampleValid = 1'b0;
  endtask

  task automatic peek(input string req, input logic [2:0] idx, input logic [7:0] exp);
    rdIndex = idx;
    #1;
    chk(req, rdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R2 reset state
    chk("R2 status", statusByte, 8'h00);
    chk("R2 drdy", drdy, 1'b0);
    peek("R2 byte0", 3'd0, 8'h00);
    rstN = 1'b1;
    tick();

    // R10 regulator bit one cycle after regOn
    regOn = 1'b1;
    tick();
    chk("R10 reg bit", statusByte, 8'h04);

    // R8 load clears ready, rises after LOWC+1 edges
    sendSample(SA);
    chk("R8 ready low after load", drdy, 1'b0);
    repeat (LOWC) tick();
    chk("R8 still low", drdy, 1'b0);
    tick();
    chk("R8 ready risen", drdy, 1'b1);
    chk("R10 status ready", statusByte, 8'h05);

    // R1 R3 R4: table of reads
    for (int i = 0; i < 8; i++) begin
      rdStrobe = 1'b1; rdIndex = RD_TAB[i][11:9];
      #1;
      chk("R1 read byte", rdData, RD_TAB[i][8:1]);
      tick();
      rdStrobe = 1'b0;
      chk("R3 R4 lock flag", statusByte[1], RD_TAB[i][0]);
      chk("R10 drdy mirrors ready", drdy, statusByte[0]);
    end

    // R6 R7 R5: held samples while locked, release by mode change
    readByte(3'd2);
    chk("R3 lock set", statusByte[1], 1'b1);
    sendSample(SB);
    peek("R6 frozen byte0", 3'd0, 8'hA1);
    chk("R6 ready untouched", drdy, 1'b1);
    sendSample(SC);
    modeChange = 1'b1;
    tick();
    modeChange = 1'b0;
    chk("R5 mode release", statusByte[1], 1'b0);
    peek("R7 not yet loaded", 3'd0, 8'hA1);
    tick();
    peek("R7 newest held byte0", 3'd0, 8'hC1);
    peek("R7 newest held byte5", 3'd5, 8'hC6);
    chk("R8 held load clears ready", drdy, 1'b0);

    // R5 configuration change release
    readByte(3'd1);
    chk("R3 lock again", statusByte[1], 1'b1);
    configChange = 1'b1;
    tick();
    configChange = 1'b0;
    chk("R5 config release", statusByte[1], 1'b0);
    peek("R5 data unchanged", 3'd0, 8'hC1);

    // R6 sample arriving in the same cycle as a read
    rdStrobe = 1'b1; rdIndex = 3'd0; sampleValid = 1'b1; sampleData = SD;
    tick();
    rdStrobe = 1'b0; sampleValid = 1'b0;
    chk("R3 lock on read", statusByte[1], 1'b1);
    peek("R6 same cycle frozen", 3'd0, 8'hC1);
    for (int k = 1; k < 6; k++) readByte(3'(k));
    peek("R6 coherent last byte", 3'd5, 8'hC6);
    chk("R4 released after all", statusByte[1], 1'b0);
    tick();
    peek("R7 held loaded", 3'd0, 8'hD1);

    // R9 off mode with pending set
    repeat (LOWC + 2) tick();
    chk("R8 ready before off", drdy, 1'b1);
    offMode = 1'b1;
    tick();
    chk("R9 off clears ready", drdy, 1'b0);
    sendSample(SE);
    repeat (3) tick();
    chk("R9 low during off", drdy, 1'b0);
    offMode = 1'b0;
    repeat (LOWC) tick();
    chk("R9 still low", drdy, 1'b0);
    tick();
    chk("R9 pending set done", drdy, 1'b1);
    peek("R9 loaded in off mode", 3'd0, 8'hE1);
    regOn = 1'b0;
    tick();
    chk("R10 reg bit cleared", statusByte, 8'h01);

    // R9 off mode with nothing pending
    offMode = 1'b1;
    tick();
    offMode = 1'b0;
    repeat (LOWC + 3) tick();
    chk("R9 no pending stays low", drdy, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule